// File: doc/BRIEF.md
# Serial Transmitter with Break Control

This block is the transmit half of a classic byte-oriented asynchronous serial port. Software writes bytes into a holding buffer that is either one entry deep or, in buffered mode, sixteen entries deep. The block moves each byte into a shift stage and drives it onto the serial line. A frame is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and high stop bits. The frame shape comes from a set of line-format inputs. The bit rate comes from a divisor.

All frame timing is kept in half-bit units. This allows a one-and-a-half stop bit period when the word is five bits long and only one stop bit is asked for. The block has two status outputs. One shows that the holding buffer is empty. The other shows that the buffer and the shift stage are both empty. A single-cycle event tells the interrupt logic when the holding buffer has drained.

A break input forces the line low. If a character is being sent when break is asserted, that character is abandoned. A transmit-reset strobe empties the holding buffer, and so does any change of the buffered-mode input.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, txd is 1, thre is 1, temt is 1 and thre_evt is 0, and the buffer starts in one-deep mode.
- R2: A frame is sent as start level 0, then 5 + word_len data bits least significant first, then parity if enabled, then stop level 1. The line is 1 while idle.
- R3: One bit lasts max(divisor,1) x 16 clock cycles. A frame lasts (2 + 2·parity_en + 10 + 2·word_len + S) half-bits, where S = 4 with two_stop, S = 3 for a 5-bit word with one stop, and S = 2 otherwise.
- R4: With parity_en = 1, the parity bit is 1 when stick_parity = 1. Otherwise it is the XOR of the data bits when even_parity = 1, and its inverse when even_parity = 0.
- R5: At the end of a frame, the next buffered byte starts in the same cycle, so no idle time appears between frames. temt is 1 only when the buffer is empty and no frame is in progress.
- R6: When the last buffered byte moves into the shift stage, thre becomes 1 and thre_evt pulses for one cycle. This does not happen if a write is accepted in the same cycle.
- R7: A write to a full buffer replaces the oldest entry and does not change the fill level. If that entry leaves for the shift stage in the same cycle, the written byte is dropped.
- R8: The buffer holds 1 byte when fifo_mode = 0 and 16 bytes when fifo_mode = 1.
- R9: While break_ctl is 1, txd is 0 from the next cycle on. Any frame in progress is abandoned, and no byte leaves the buffer. After break_ctl returns to 0, sending resumes with the oldest buffered byte.
- R10: A tx_fifo_rst pulse empties the buffer and ignores a write in the same cycle. A frame already in the shift stage keeps going. thre_evt pulses only if the buffer is then in 16-deep mode.
- R11: Any change of fifo_mode empties the buffer exactly as R10 does, using the new mode to decide whether thre_evt pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr | input | 1 | Write strobe for the holding buffer |
| thr_data | input | 8 | Byte to write |
| word_len | input | 2 | Data bits minus five |
| two_stop | input | 1 | Selects the longer stop period |
| parity_en | input | 1 | Adds a parity bit |
| even_parity | input | 1 | Selects even parity (1) or odd parity (0) |
| stick_parity | input | 1 | Forces the parity bit to 1 |
| break_ctl | input | 1 | Holds the line low |
| divisor | input | DIV_W | Bit-rate divisor; 0 acts as 1 |
| tx_fifo_rst | input | 1 | Strobe that empties the holding buffer |
| fifo_mode | input | 1 | Selects 16-deep (1) or 1-deep (0) buffering |
| txd | output | 1 | Serial line |
| thre | output | 1 | Holding buffer is empty |
| temt | output | 1 | Buffer and shift stage are both empty |
| thre_evt | output | 1 | One-cycle pulse when the buffer becomes empty |

## Verification
The bound checker checks the following invariants on every cycle:
- thre_evt never appears unless the buffer is empty.
- temt never appears unless thre is also 1.
- A break cycle is always followed by a low line.
- The fill level stays within the capacity of the current mode.
- A transmit reset always leaves the buffer empty.

Some behaviour can only be shown by the bench's scenarios, which compare against a queue-based reference on every clock:
- the exact frame bit order, parity values and half-bit durations;
- the 1.5-stop case and the zero divisor;
- back-to-back frames;
- overwriting the oldest entry of a full buffer;
- abandoning a frame on break and resuming after it;
- event pulses that depend on the buffer mode.

// File: rtl/uxt_pkg.sv
package uxt_pkg;
    localparam int FRAME_BITS = 12;
    localparam int HALF_W     = 5;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       even_par;
        logic       stick_par;
    } line_cfg_t;
endpackage

// File: rtl/uxt_framer.sv
module uxt_framer
    import uxt_pkg::*;
(
    input  line_cfg_t             cfg,
    input  logic [7:0]            data,
    output logic [FRAME_BITS-1:0] frame,
    output logic [HALF_W-1:0]     halves
);
    logic par;
    int   pidx;

    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        par      = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < 5 + int'(cfg.wlen)) begin
                frame[i + 1] = data[i];
                par          = par ^ data[i];
            end
        end
        pidx = 6 + int'(cfg.wlen);
        if (cfg.par_en) begin
            frame[pidx] = cfg.stick_par ? 1'b1 : (cfg.even_par ? par : ~par);
        end
        halves = 5'd12 + 5'({cfg.wlen, 1'b0})
               + (cfg.par_en ? 5'd2 : 5'd0)
               + (cfg.two_stop ? 5'd4 : ((cfg.wlen != 2'd0) ? 5'd2 : 5'd3));
    end
endmodule

// File: rtl/uxt_hold_buf.sv
module uxt_hold_buf #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             deep,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] fill,
    output logic             accept
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } buf_st_t;

    buf_st_t    st_d, st_q;
    logic [7:0] mem [DEPTH];
    logic [CNT_W-1:0] cap;
    logic       full;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p, input logic dp);
        return (dp && p != PTR_W'(DEPTH - 1)) ? p + 1'b1 : '0;
    endfunction

    always_comb begin
        cap    = deep ? CNT_W'(DEPTH) : CNT_W'(1);
        full   = (st_q.cnt == cap);
        accept = wr_en && !full && !flush;
        st_d   = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (accept) st_d.wp = step(st_q.wp, deep);
            if (rd_en)  st_d.rp = step(st_q.rp, deep);
            st_d.cnt = st_q.cnt + CNT_W'(accept) - CNT_W'(rd_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) mem[st_q.wp] <= wr_data;
    end

    assign rd_data = mem[st_q.rp];
    assign fill    = st_q.cnt;
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
    import uxt_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int DIV_W      = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_wr,
    input  logic [7:0]       thr_data,
    input  logic [1:0]       word_len,
    input  logic             two_stop,
    input  logic             parity_en,
    input  logic             even_parity,
    input  logic             stick_parity,
    input  logic             break_ctl,
    input  logic [DIV_W-1:0] divisor,
    input  logic             tx_fifo_rst,
    input  logic             fifo_mode,
    output logic             txd,
    output logic             thre,
    output logic             temt,
    output logic             thre_evt
);
    localparam int HALF_CLKS = OVERSAMPLE / 2;
    localparam int PRE_W     = DIV_W + $clog2(HALF_CLKS);
    localparam int CNT_W     = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                  busy;
        logic [HALF_W-1:0]     hcnt;
        logic [HALF_W-1:0]     nhalf;
        logic [FRAME_BITS-1:0] frame;
        logic [PRE_W-1:0]      pre;
        logic                  mode;
        logic                  txd;
        logic                  evt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    line_cfg_t             cfg;
    logic [7:0]            head;
    logic [CNT_W-1:0]      fill;
    logic                  accept;
    logic [FRAME_BITS-1:0] new_frame;
    logic [HALF_W-1:0]     new_halves;
    logic [DIV_W-1:0]      div_eff;
    logic [PRE_W-1:0]      half_len;
    logic                  tick, done, flush, load;
    logic                  deep_mode;

    assign cfg = '{wlen: word_len, two_stop: two_stop, par_en: parity_en,
                   even_par: even_parity, stick_par: stick_parity};

    uxt_framer framer_i (
        .cfg    (cfg),
        .data   (head),
        .frame  (new_frame),
        .halves (new_halves)
    );

    uxt_hold_buf #(.DEPTH(DEPTH)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .deep    (st_q.mode),
        .wr_en   (thr_wr),
        .wr_data (thr_data),
        .rd_en   (load),
        .rd_data (head),
        .fill    (fill),
        .accept  (accept)
    );

    always_comb begin
        div_eff  = (divisor == '0) ? DIV_W'(1) : divisor;
        half_len = PRE_W'(div_eff) * PRE_W'(HALF_CLKS);
        tick     = (st_q.pre == half_len - 1'b1);
        done     = st_q.busy && tick && (st_q.hcnt == st_q.nhalf - 1'b1);
        flush    = tx_fifo_rst || (fifo_mode != st_q.mode);
        load     = !break_ctl && (!st_q.busy || done) && (fill != '0) && !flush;

        st_d      = st_q;
        st_d.mode = fifo_mode;
        st_d.evt  = flush ? fifo_mode : (load && fill == CNT_W'(1) && !accept);

        if (break_ctl) begin
            st_d.busy = 1'b0;
            st_d.hcnt = '0;
            st_d.pre  = '0;
        end else if (load) begin
            st_d.busy  = 1'b1;
            st_d.hcnt  = '0;
            st_d.pre   = '0;
            st_d.nhalf = new_halves;
            st_d.frame = new_frame;
        end else if (st_q.busy) begin
            if (tick) begin
                st_d.pre = '0;
                if (done) st_d.busy = 1'b0;
                else      st_d.hcnt = st_q.hcnt + 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end

        if (break_ctl)      st_d.txd = 1'b0;
        else if (st_d.busy) st_d.txd = st_d.frame[st_d.hcnt[HALF_W-1:1]];
        else                st_d.txd = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.txd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign deep_mode = st_q.mode;
    assign txd       = st_q.txd;
    assign thre      = (fill == '0);
    assign temt      = thre && !st_q.busy;
    assign thre_evt  = st_q.evt;
endmodule

// File: rtl/uxt_tx_checker.sv
module uxt_tx_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             break_ctl,
    input logic             tx_fifo_rst,
    input logic             txd,
    input logic             thre,
    input logic             temt,
    input logic             thre_evt,
    input logic [CNT_W-1:0] fill,
    input logic             deep_mode
);
    // R6
    evt_implies_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thre_evt |-> thre);
    // R5
    temt_implies_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> thre);
    // R9
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_ctl |=> !txd);
    // R8
    fill_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(fill) <= DEPTH) && (deep_mode || 32'(fill) <= 1));
    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_rst |=> thre);
endmodule

bind serial_tx_core uxt_tx_checker #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .break_ctl   (break_ctl),
    .tx_fifo_rst (tx_fifo_rst),
    .txd         (txd),
    .thre        (thre),
    .temt        (temt),
    .thre_evt    (thre_evt),
    .fill        (fill),
    .deep_mode   (deep_mode)
);

// File: tb/serial_tx_core_tb_top.sv
`timescale 1ns/1ps
module serial_tx_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        thr_wr = 1'b0;
    logic [7:0]  thr_data = '0;
    logic [1:0]  word_len = 2'd3;
    logic        two_stop = 1'b0, parity_en = 1'b0, even_parity = 1'b0, stick_parity = 1'b0;
    logic        break_ctl = 1'b0, tx_fifo_rst = 1'b0, fifo_mode = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic        txd, thre, temt, thre_evt;

    int    checks = 0, failures = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    logic [7:0] q[$];
    bit         hq[$];
    bit         m_busy = 0, m_mode = 0;
    int         m_pc = 0;
    bit         exp_txd = 1, exp_thre = 1, exp_temt = 1, exp_evt = 0;

    always #4 clk = ~clk;

    serial_tx_core dut_i (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_data(thr_data),
        .word_len(word_len), .two_stop(two_stop), .parity_en(parity_en),
        .even_parity(even_parity), .stick_parity(stick_parity),
        .break_ctl(break_ctl), .divisor(divisor), .tx_fifo_rst(tx_fifo_rst),
        .fifo_mode(fifo_mode), .txd(txd), .thre(thre), .temt(temt),
        .thre_evt(thre_evt)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    function automatic void build_halves(input logic [7:0] d);
        int nb = 5 + int'(word_len);
        bit p = 1'b0;
        int ns;
        hq.delete();
        hq.push_back(1'b0); hq.push_back(1'b0);
        for (int i = 0; i < nb; i++) begin
            hq.push_back(d[i]); hq.push_back(d[i]);
            p = p ^ d[i];
        end
        if (parity_en) begin
            bit pb = stick_parity ? 1'b1 : (even_parity ? p : !p);
            hq.push_back(pb); hq.push_back(pb);
        end
        ns = two_stop ? 4 : ((word_len != 2'd0) ? 2 : 3);
        for (int i = 0; i < ns; i++) hq.push_back(1'b1);
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        int hl, cap;
        bit tick, done, flush, load;
        logic [7:0] head;
        if (!rst_n) begin
            q.delete(); hq.delete();
            m_busy = 0; m_pc = 0; m_mode = 0; exp_evt = 0; exp_txd = 1;
        end else begin
            hl    = ((divisor == 0) ? 1 : int'(divisor)) * 8;
            tick  = (m_pc == hl - 1);
            done  = m_busy && tick && (hq.size() == 1);
            flush = tx_fifo_rst || (fifo_mode != m_mode);
            cap   = m_mode ? 16 : 1;
            load  = !break_ctl && (!m_busy || done) && (q.size() > 0) && !flush;
            head  = '0;
            exp_evt = 0;
            if (flush) begin
                q.delete();
                exp_evt = fifo_mode;
            end else begin
                if (load) head = q[0];
                if (thr_wr) begin
                    if (q.size() < cap) q.push_back(thr_data);
                    else if (!load)     q[0] = thr_data;
                end
                if (load) begin
                    void'(q.pop_front());
                    if (q.size() == 0) exp_evt = 1;
                end
            end
            m_mode = fifo_mode;
            if (break_ctl) begin
                m_busy = 0; hq.delete(); m_pc = 0;
            end else if (load) begin
                build_halves(head); m_busy = 1; m_pc = 0;
            end else if (m_busy) begin
                if (tick) begin
                    m_pc = 0;
                    void'(hq.pop_front());
                    if (hq.size() == 0) m_busy = 0;
                end else begin
                    m_pc++;
                end
            end
            exp_txd = break_ctl ? 1'b0 : (m_busy ? hq[0] : 1'b1);
        end
        exp_thre = (q.size() == 0);
        exp_temt = exp_thre && !m_busy;
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(txd === exp_txd,       "txd",      int'(txd),      int'(exp_txd));
            chk(thre === exp_thre,     "thre",     int'(thre),     int'(exp_thre));
            chk(temt === exp_temt,     "temt",     int'(temt),     int'(exp_temt));
            chk(thre_evt === exp_evt,  "thre_evt", int'(thre_evt), int'(exp_evt));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        thr_wr = 1'b1; thr_data = d;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!exp_temt || !temt);
        cycles(3);
    endtask

    task automatic line(input logic [1:0] wl, input bit ts, input bit pe,
                        input bit ep, input bit sp, input logic [15:0] dv);
        @(negedge clk);
        word_len = wl; two_stop = ts; parity_en = pe;
        even_parity = ep; stick_parity = sp; divisor = dv;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired in %s", cur_req);
        summary();
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        @(negedge clk);
        chk(txd === 1'b1, "reset txd", int'(txd), 1);
        chk(thre === 1'b1, "reset thre", int'(thre), 1);
        chk(temt === 1'b1, "reset temt", int'(temt), 1);
        chk(thre_evt === 1'b0, "reset thre_evt", int'(thre_evt), 0);

        cur_req = "R2";
        line(2'd3, 0, 0, 0, 0, 16'd1);
        write_byte(8'hA5); wait_idle();
        write_byte(8'h3C); wait_idle();

        cur_req = "R3";
        line(2'd0, 0, 0, 0, 0, 16'd2);
        write_byte(8'h1B); wait_idle();
        line(2'd0, 1, 0, 0, 0, 16'd1);
        write_byte(8'h0A); wait_idle();
        line(2'd3, 1, 0, 0, 0, 16'd0);
        write_byte(8'h55); wait_idle();

        cur_req = "R4";
        line(2'd2, 0, 1, 1, 0, 16'd1);
        write_byte(8'h35); wait_idle();
        line(2'd2, 0, 1, 0, 0, 16'd1);
        write_byte(8'h35); wait_idle();
        line(2'd3, 0, 1, 1, 1, 16'd1);
        write_byte(8'h00); wait_idle();
        line(2'd1, 0, 1, 0, 0, 16'd1);
        write_byte(8'h2F); wait_idle();

        cur_req = "R6";
        line(2'd3, 0, 0, 0, 0, 16'd1);
        write_byte(8'h81); wait_idle();

        cur_req = "R7";
        write_byte(8'h11); write_byte(8'h22); cycles(5);
        write_byte(8'h33); wait_idle();

        cur_req = "R11";
        @(negedge clk); fifo_mode = 1'b1;
        cycles(4);

        cur_req = "R5";
        for (int i = 0; i < 4; i++) write_byte(8'h40 + 8'(i));
        wait_idle();

        cur_req = "R8";
        for (int i = 0; i < 18; i++) write_byte(8'h60 + 8'(i));
        cycles(200);
        cur_req = "R7";
        write_byte(8'hEE);
        wait_idle();

        cur_req = "R9";
        write_byte(8'hC3); write_byte(8'h5A);
        cycles(40);
        @(negedge clk); break_ctl = 1'b1;
        cycles(50);
        @(negedge clk); break_ctl = 1'b0;
        wait_idle();
        @(negedge clk); break_ctl = 1'b1;
        cycles(10);
        @(negedge clk); break_ctl = 1'b0;
        cycles(5);

        cur_req = "R10";
        for (int i = 0; i < 5; i++) write_byte(8'h90 + 8'(i));
        cycles(30);
        @(negedge clk); tx_fifo_rst = 1'b1;
        @(negedge clk); tx_fifo_rst = 1'b0;
        wait_idle();

        cur_req = "R11";
        @(negedge clk); fifo_mode = 1'b0;
        cycles(4);

        cur_req = "R10";
        write_byte(8'hA1); write_byte(8'hB2); cycles(10);
        @(negedge clk); tx_fifo_rst = 1'b1;
        @(negedge clk); tx_fifo_rst = 1'b0;
        wait_idle();

        summary();
    end
endmodule